// File: doc/BRIEF.md
# Incrementing-Pattern Self-Test Checker

This block watches one receive lane, after 8B/10B decoding, while the link runs its built-in self-test. On every word clock it looks at the decoded byte, a flag that marks the word as a control character, and a flag that marks a receiver error such as a code or disparity violation. It has one pass/fail output. That output is high while errors are present or no good frame has been seen yet. It goes low once a full, correct test frame has arrived.

A test frame is one or more idle characters followed by every data value from 0x00 to 0xFF in rising order. The number of idles between frames is free, because idles may be inserted or removed further down the receive path. The checker locks onto the frame at the idles and not at a fixed word count. Each lane has its own checker and no alignment between lanes is attempted. The decoded byte and both flags go to the lane's normal outputs unchanged whether the self-test is on or off.

Top module: `bist_lane_checker`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the fail output is high.
- R2: While the test enable is low, the fail output is held high and the checker forgets any partial frame. A rising enable therefore starts with the fail output high.
- R3: A word with the receiver-error flag set drives the fail output high on the next clock.
- R4: Suppose at least one idle is followed by data 0x00, 0x01, ... 0xFF, all received without error. The fail output then goes low on the clock after 0xFF is sampled. An idle is the control flag set with byte 0xBC.
- R5: Any number of consecutive idles, one or more, is accepted before a frame.
- R6: A data byte that does not equal the expected value drives the fail output high. This includes a first byte after the idles that is not 0x00.
- R7: A control character other than the idle, or an idle arriving in the middle of a data run, drives the fail output high. The data words that follow are then ignored until the next idle re-arms the checker.
- R8: Once 0xFF has been received, a data byte arriving before an idle counts as a mismatch.
- R9: The byte, control flag and error flag appear unchanged on the lane outputs in the same cycle.
- R10: After the fail output has gone low, it stays low through later correct frames and their idles. After an error it clears only after another complete good frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Self-test enable |
| rx_byte_i | input | 8 | Decoded byte |
| rx_ctrl_i | input | 1 | High when the byte is a control character |
| rx_err_i | input | 1 | Receiver code or disparity error |
| rx_byte_o | output | 8 | Byte passed through |
| rx_ctrl_o | output | 1 | Control flag passed through |
| rx_err_o | output | 1 | Error flag passed through |
| bist_fail_o | output | 1 | High = errors or no good frame yet; low = pattern received correctly |

## Verification
The assertions assume that every clock carries exactly one decoded word, with no valid or gap strobe. They also assume that the enable changes only at clock boundaries. The bench drives each word on the falling edge and holds it for a whole cycle. It toggles the enable only between words, so every word is seen exactly once. Error words, stray control characters and early idles are placed at chosen positions within otherwise clean frames, so that each case is exercised on its own.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    WK_DATA    = 2'd0,
    WK_IDLE    = 2'd1,
    WK_BADCTRL = 2'd2,
    WK_RXERR   = 2'd3
  } word_kind_t;
endpackage

// File: rtl/bist_word_class.sv
module bist_word_class
  import bist_chk_pkg::*;
#(
  parameter int unsigned            DATA_W    = 8,
  parameter logic [DATA_W-1:0]      IDLE_CODE = 8'hBC
) (
  input  logic              err_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] byte_i,
  output word_kind_t        kind_o
);
  function automatic word_kind_t classify(input logic e, input logic c,
                                          input logic [DATA_W-1:0] b);
    if (e)                   return WK_RXERR;
    else if (!c)             return WK_DATA;
    else if (b == IDLE_CODE) return WK_IDLE;
    else                     return WK_BADCTRL;
  endfunction

  assign kind_o = classify(err_i, ctrl_i, byte_i);
endmodule

// File: rtl/bist_seq_tracker.sv
module bist_seq_tracker
  import bist_chk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  word_kind_t        kind_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              ev_pass_o,
  output logic              ev_fail_o
);
  localparam logic [DATA_W-1:0] FIRST_VAL = '0;

  function automatic logic [DATA_W-1:0] step_value(input logic [DATA_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic is_last(input logic [DATA_W-1:0] v);
    return &v;
  endfunction

  seq_state_t        st_q, st_d;
  logic [DATA_W-1:0] exp_q, exp_d;

  always_comb begin
    st_d      = st_q;
    exp_d     = exp_q;
    ev_pass_o = 1'b0;
    ev_fail_o = 1'b0;
    if (!en_i) begin
      st_d  = ST_HUNT;
      exp_d = FIRST_VAL;
    end else begin
      unique case (kind_i)
        WK_RXERR, WK_BADCTRL: begin
          ev_fail_o = 1'b1;
          st_d      = ST_HUNT;
        end
        WK_IDLE: begin
          if (st_q == ST_RUN) begin
            ev_fail_o = 1'b1;
            st_d      = ST_HUNT;
          end else begin
            st_d  = ST_ARMED;
            exp_d = FIRST_VAL;
          end
        end
        default: begin
          unique case (st_q)
            ST_HUNT: st_d = ST_HUNT;
            ST_ARMED: begin
              if (byte_i == FIRST_VAL) begin
                st_d  = ST_RUN;
                exp_d = step_value(FIRST_VAL);
              end else begin
                ev_fail_o = 1'b1;
                st_d      = ST_HUNT;
              end
            end
            ST_RUN: begin
              if (byte_i != exp_q) begin
                ev_fail_o = 1'b1;
                st_d      = ST_HUNT;
              end else if (is_last(exp_q)) begin
                ev_pass_o = 1'b1;
                st_d      = ST_DONE;
              end else begin
                exp_d = step_value(exp_q);
              end
            end
            default: begin
              ev_fail_o = 1'b1;
              st_d      = ST_HUNT;
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      exp_q <= FIRST_VAL;
    end else begin
      st_q  <= st_d;
      exp_q <= exp_d;
    end
  end
endmodule

// File: rtl/bist_status_reg.sv
module bist_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ev_pass_i,
  input  logic ev_fail_i,
  output logic fail_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fail_o <= 1'b1;
    else if (!en_i)     fail_o <= 1'b1;
    else if (ev_fail_i) fail_o <= 1'b1;
    else if (ev_pass_i) fail_o <= 1'b0;
  end
endmodule

// File: rtl/bist_lane_checker.sv
module bist_lane_checker
  import bist_chk_pkg::*;
#(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_CODE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_ctrl_i,
  input  logic              rx_err_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_ctrl_o,
  output logic              rx_err_o,
  output logic              bist_fail_o
);
  word_kind_t kind;
  logic       ev_pass;
  logic       ev_fail;

  assign rx_byte_o = rx_byte_i;
  assign rx_ctrl_o = rx_ctrl_i;
  assign rx_err_o  = rx_err_i;

  bist_word_class #(.DATA_W(DATA_W), .IDLE_CODE(IDLE_CODE)) u_class (
    .err_i  (rx_err_i),
    .ctrl_i (rx_ctrl_i),
    .byte_i (rx_byte_i),
    .kind_o (kind)
  );

  bist_seq_tracker #(.DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (bist_en),
    .kind_i    (kind),
    .byte_i    (rx_byte_i),
    .ev_pass_o (ev_pass),
    .ev_fail_o (ev_fail)
  );

  bist_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (bist_en),
    .ev_pass_i (ev_pass),
    .ev_fail_i (ev_fail),
    .fail_o    (bist_fail_o)
  );
endmodule

// File: rtl/bist_lane_checker_sva.sv
module bist_lane_checker_sva #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] IDLE_CODE = 8'hBC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bist_en,
  input logic [DATA_W-1:0] rx_byte_i,
  input logic              rx_ctrl_i,
  input logic              rx_err_i,
  input logic              bist_fail_o,
  input logic              ev_pass
);
  // R2
  en_low_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> bist_fail_o);

  // R3
  rx_err_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && rx_err_i) |=> bist_fail_o);

  // R4
  clear_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bist_fail_o) |-> $past(bist_en && !rx_ctrl_i && !rx_err_i && (&rx_byte_i)));

  // R4
  pass_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |-> (bist_en && !rx_ctrl_i && !rx_err_i && (&rx_byte_i)));

  // R7
  bad_ctrl_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && rx_ctrl_i && rx_byte_i != IDLE_CODE) |=> bist_fail_o);
endmodule

bind bist_lane_checker bist_lane_checker_sva #(.DATA_W(DATA_W), .IDLE_CODE(IDLE_CODE)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .bist_en     (bist_en),
  .rx_byte_i   (rx_byte_i),
  .rx_ctrl_i   (rx_ctrl_i),
  .rx_err_i    (rx_err_i),
  .bist_fail_o (bist_fail_o),
  .ev_pass     (ev_pass)
);

// File: tb/bist_lane_checker_tb_top.sv
`timescale 1ns/1ps
module bist_lane_checker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bist_en;
  logic [7:0] rx_byte_i;
  logic       rx_ctrl_i;
  logic       rx_err_i;
  logic [7:0] rx_byte_o;
  logic       rx_ctrl_o;
  logic       rx_err_o;
  logic       bist_fail_o;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag  = "R1";
  bit    done     = 1'b0;

  // reference model: 0 hunting, 1 idles seen, 2 in data run, 3 frame complete
  int m_phase = 0;
  int m_next  = 0;
  bit m_fail  = 1'b1;

  always #4 clk = ~clk;

  bist_lane_checker dut_i (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en),
    .rx_byte_i(rx_byte_i), .rx_ctrl_i(rx_ctrl_i), .rx_err_i(rx_err_i),
    .rx_byte_o(rx_byte_o), .rx_ctrl_o(rx_ctrl_o), .rx_err_o(rx_err_o),
    .bist_fail_o(bist_fail_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_word(input int b, input bit c, input bit e, input bit en);
    if (!en) begin
      m_phase = 0; m_fail = 1'b1;
    end else if (e || (c && b != 188)) begin
      m_phase = 0; m_fail = 1'b1;
    end else if (c) begin
      if (m_phase == 2) begin m_phase = 0; m_fail = 1'b1; end
      else m_phase = 1;
    end else begin
      case (m_phase)
        1: if (b == 0) begin m_phase = 2; m_next = 1; end
           else begin m_phase = 0; m_fail = 1'b1; end
        2: if (b == m_next) begin
             if (m_next == 255) begin m_phase = 3; m_fail = 1'b0; end
             else m_next = m_next + 1;
           end else begin m_phase = 0; m_fail = 1'b1; end
        3: begin m_phase = 0; m_fail = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input int b, input bit c, input bit e);
    rx_byte_i = b[7:0]; rx_ctrl_i = c; rx_err_i = e;
    #1;
    // R9 pass-through in the same cycle
    check("R9 byte", int'(rx_byte_o), b & 255);
    check("R9 ctrl", int'(rx_ctrl_o), int'(c));
    check("R9 err",  int'(rx_err_o),  int'(e));
    @(posedge clk);
    model_word(b, c, e, bist_en);
    @(negedge clk);
    check(cur_tag, int'(bist_fail_o), int'(m_fail));
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) step(188, 1'b1, 1'b0);
  endtask

  task automatic frame();
    for (int v = 0; v < 256; v++) step(v, 1'b0, 1'b0);
  endtask

  task automatic partial(input int upto);
    for (int v = 0; v < upto; v++) step(v, 1'b0, 1'b0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bist_en = 1'b0;
    rx_byte_i = '0; rx_ctrl_i = 1'b0; rx_err_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(bist_fail_o), 1);
    rst_n = 1'b1;
    cur_tag = "R1"; step(0, 1'b0, 1'b0);

    cur_tag = "R2"; idles(2); frame();           // enable low: stays high
    bist_en = 1'b1;
    cur_tag = "R2"; step(5, 1'b0, 1'b0);
    cur_tag = "R5"; idles(3);
    cur_tag = "R4"; frame();
    check("R4 cleared", int'(bist_fail_o), 0);
    cur_tag = "R10"; idles(1); frame(); idles(5); frame();
    check("R10 still low", int'(bist_fail_o), 0);

    cur_tag = "R3"; idles(1); partial(40); step(40, 1'b0, 1'b1);
    check("R3 high", int'(bist_fail_o), 1);
    cur_tag = "R7"; for (int v = 41; v < 256; v++) step(v, 1'b0, 1'b0);
    check("R7 ignored until idle", int'(bist_fail_o), 1);
    cur_tag = "R10"; idles(2); frame();

    cur_tag = "R6"; idles(1); partial(55); step(99, 1'b0, 1'b0);
    check("R6 mismatch", int'(bist_fail_o), 1);
    cur_tag = "R6"; idles(1); frame();
    cur_tag = "R6"; idles(1); step(1, 1'b0, 1'b0);
    check("R6 bad first", int'(bist_fail_o), 1);

    cur_tag = "R7"; idles(1); partial(10); step(252, 1'b1, 1'b0);
    check("R7 bad ctrl", int'(bist_fail_o), 1);
    cur_tag = "R4"; idles(1); frame();
    cur_tag = "R7"; idles(1); partial(100); idles(1);
    check("R7 idle mid-run", int'(bist_fail_o), 1);
    cur_tag = "R7"; partial(20); idles(1); frame();

    cur_tag = "R8"; step(0, 1'b0, 1'b0);
    check("R8 no idle", int'(bist_fail_o), 1);
    cur_tag = "R8"; idles(1); frame();

    cur_tag = "R2"; idles(1); partial(30); bist_en = 1'b0; step(30, 1'b0, 1'b0);
    bist_en = 1'b1; step(31, 1'b0, 1'b0);
    check("R2 after re-enable", int'(bist_fail_o), 1);
    cur_tag = "R4"; idles(4); frame();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule